// File: doc/BRIEF.md
# Staged-Commit Transmit Packet Queue

This block is a quadlet-wide transmit queue that software fills one quadlet at a time through a register bus. The write address carries the framing. One address opens a packet, another appends to it, and a third appends the closing quadlet and releases the whole packet to the transmitter. Until that release, the transmitter cannot see any quadlet of the packet. The queue keeps a raw write pointer, a commit pointer and a read pointer. A commit moves the commit pointer up to the raw pointer in a single step, so every quadlet written since the previous commit becomes visible together.

When a commit lands in a queue that holds no committed data, the empty flag drops and a one-cycle arbitration request is raised toward the bus arbiter. Two faults latch the queue into a stuck state: a packet that does not begin at an opening address, and a read past the committed data. While stuck, the read side is blocked and further writes and pops do nothing. Only a pulse on the clear input releases it, and that pulse also empties the queue.

A parameter selects one of two address maps. The asynchronous map has open, append and close addresses. The isochronous map adds a fourth address that opens and closes a one-quadlet packet in one write. Each instance keeps its own stuck state, so a system with one queue of each kind keeps transmitting from the healthy queue while the other is stuck.

Top module: `txq_commit_fifo`

## Requirements
- R1: Address decode uses the low address byte. With ISO_MAP=0, 80h opens a packet, 84h appends and 8Ch closes it. With ISO_MAP=1, 90h opens, 94h appends, 9Ch closes and 98h opens and closes in one write. Writes to any other address, including the other map's addresses, have no effect.
- R2: Quadlets of a packet that is not yet closed are not visible: rd_valid stays low and empty stays high. The close write makes all of the packet's quadlets readable from the next cycle.
- R3: Committed quadlets are read in write order. rd_last is 1 exactly on the closing quadlet of each packet.
- R4: An append or close write while no packet is open enters the stuck state. A packet is open after an open write and not open after a close.
- R5: A pop (rd_en) while no committed data is present and the queue is not stuck enters the stuck state.
- R6: While stuck, rd_valid is 0, the stuck output stays 1, and writes and pops have no effect.
- R7: A clear pulse empties the queue, leaves the stuck state and clears the overflow flag. It takes precedence over a write or pop in the same cycle.
- R8: A commit that occurs while no committed data is present raises arb_req for exactly one cycle, in the cycle after the commit edge, and empty goes low at the same edge. A commit into a queue that already holds committed data raises no request.
- R9: An open write while a packet is still open discards that packet's uncommitted quadlets.
- R10: With DEPTH entries already occupied, a write is dropped, has no other effect and sets a sticky overflow flag. Filling the queue exactly to DEPTH does not set the flag.
- R11: After reset, empty=1, rd_valid=0, arb_req=0, stuck=0 and overflow=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register bus write strobe |
| wr_addr | input | ADDR_W | Register bus write address (framing encoded) |
| wr_data | input | DATA_W | Quadlet to enqueue |
| clr_fifo | input | 1 | Clear control bit write: empties queue, releases stuck |
| rd_en | input | 1 | Transmitter pops the quadlet at the head |
| rd_data | output | DATA_W | Head quadlet |
| rd_valid | output | 1 | Head holds committed data and queue is not stuck |
| rd_last | output | 1 | Head quadlet closes its packet |
| empty | output | 1 | No committed data present |
| arb_req | output | 1 | One-cycle bus arbitration request |
| stuck | output | 1 | Stuck state (interrupt level) |
| overflow | output | 1 | Sticky flag: a write was dropped on a full queue |

## Verification
The close write of one packet and a pop by the transmitter can happen in the same cycle. When this happens, the request logic must judge emptiness from the state before the edge, and the read and commit pointers must move together. The bench provokes this by holding a committed packet, opening a second packet, and then asserting the close write and rd_en on the same edge. It then expects no arbitration pulse, the head quadlet consumed, and the remaining quadlets of both packets read back in order with the right last markers. The bench also pairs a framing fault with a pop, and a clear with a write, in the same cycle. For each pair it checks which of the two actions takes effect.

// File: rtl/txq_pkg.sv
// Package: shared types and address bases for the staged-commit transmit queue.
// Assumes the low address byte selects the queue register.
package txq_pkg;

    // Framing meaning of one register write
    typedef enum logic [2:0] {
        WK_NONE,
        WK_FIRST,
        WK_MID,
        WK_COMMIT,
        WK_FIRST_COMMIT
    } wkind_e;

    // Fault latch state of one queue
    typedef enum logic {
        QS_RUN,
        QS_STUCK
    } qstate_e;

    localparam logic [7:0] ASYNC_BASE = 8'h80;
    localparam logic [7:0] ISO_BASE   = 8'h90;
    localparam logic [7:0] OFF_FIRST  = 8'h00;
    localparam logic [7:0] OFF_MID    = 8'h04;
    localparam logic [7:0] OFF_FCOMM  = 8'h08;
    localparam logic [7:0] OFF_COMMIT = 8'h0C;

endpackage

// File: rtl/txq_addr_decode.sv
// Module: txq_addr_decode
// Turns a register bus write into a framing kind. ISO_MAP picks the map:
// the isochronous map adds an open-and-close address; the asynchronous map
// leaves that offset unmapped. Purely combinational.
// Assumes ADDR_W >= 8; only the low byte is compared.
module txq_addr_decode
    import txq_pkg::*;
#(
    parameter int ISO_MAP = 0,
    parameter int ADDR_W  = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wkind_e            kind
);

    localparam logic [7:0] BASE = (ISO_MAP != 0) ? ISO_BASE : ASYNC_BASE;

    logic [7:0] low_byte;
    assign low_byte = wr_addr[7:0];

    if (ADDR_W > 8) begin : g_upper
        logic unused_upper;
        assign unused_upper = ^wr_addr[ADDR_W-1:8];
    end

    generate
        if (ISO_MAP != 0) begin : g_iso
            // Isochronous map: four framing addresses
            always_comb begin
                kind = WK_NONE;
                if (wr_en) begin
                    if (low_byte == BASE + OFF_FIRST)       kind = WK_FIRST;
                    else if (low_byte == BASE + OFF_MID)    kind = WK_MID;
                    else if (low_byte == BASE + OFF_FCOMM)  kind = WK_FIRST_COMMIT;
                    else if (low_byte == BASE + OFF_COMMIT) kind = WK_COMMIT;
                end
            end
        end else begin : g_async
            // Asynchronous map: open, append, close
            always_comb begin
                kind = WK_NONE;
                if (wr_en) begin
                    if (low_byte == BASE + OFF_FIRST)       kind = WK_FIRST;
                    else if (low_byte == BASE + OFF_MID)    kind = WK_MID;
                    else if (low_byte == BASE + OFF_COMMIT) kind = WK_COMMIT;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/txq_store.sv
// Module: txq_store
// Storage array: one data quadlet plus a packet-end bit per slot.
// Single write port, asynchronous read port. Slots are not reset; the
// controller never exposes an unwritten slot as valid.
module txq_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wlast,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rlast
);

    logic [DATA_W:0] slots [DEPTH];

    // Capture an accepted quadlet with its packet-end mark
    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= {wlast, wdata};
    end

    // Present the head slot to the transmitter
    always_comb begin
        rdata = slots[raddr][DATA_W-1:0];
        rlast = slots[raddr][DATA_W];
    end

endmodule

// File: rtl/txq_frame_ctrl.sv
// Module: txq_frame_ctrl
// Pointer and framing control. Holds raw write, commit and read pointers
// (one wrap bit each), the open-packet flag, the stuck latch, the sticky
// overflow flag and the arbitration pulse.
// Assumes DEPTH is a power of two. Fullness is judged against the read
// pointer before the edge, so a pop in the same cycle frees no slot yet.
module txq_frame_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  wkind_e        kind,
    input  logic          rd_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic          mem_wlast,
    output logic [AW-1:0] mem_raddr,
    output logic          rd_valid,
    output logic          empty,
    output logic          arb_req,
    output logic          stuck,
    output logic          overflow
);

    logic [PW-1:0] wptr_q, cptr_q, rptr_q;
    logic          open_q, ovf_q, arb_q;
    qstate_e       state_q;

    logic          is_first, is_commit, is_cont, active;
    logic [PW-1:0] wbase;
    logic          full, misuse, accept, drop;
    logic          comm_empty, head_ok, popping, underflow;

    // Classify the write and decide whether it is accepted
    always_comb begin
        is_first   = (kind == WK_FIRST) || (kind == WK_FIRST_COMMIT);
        is_commit  = (kind == WK_COMMIT) || (kind == WK_FIRST_COMMIT);
        is_cont    = (kind == WK_MID) || (kind == WK_COMMIT);
        active     = (kind != WK_NONE) && (state_q == QS_RUN) && !clr;
        wbase      = is_first ? cptr_q : wptr_q;
        full       = (wbase - rptr_q) == PW'(DEPTH);
        misuse     = active && is_cont && !open_q;
        accept     = active && !misuse && !full;
        drop       = active && !misuse && full;
        comm_empty = (cptr_q == rptr_q);
        head_ok    = !comm_empty && (state_q == QS_RUN);
        popping    = rd_en && head_ok && !clr;
        underflow  = rd_en && comm_empty && (state_q == QS_RUN) && !clr;
    end

    // Update pointers, framing flag, fault latch and flags
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr_q  <= '0;
            cptr_q  <= '0;
            rptr_q  <= '0;
            open_q  <= 1'b0;
            ovf_q   <= 1'b0;
            arb_q   <= 1'b0;
            state_q <= QS_RUN;
        end else begin
            arb_q <= accept && is_commit && comm_empty;
            if (popping) rptr_q <= rptr_q + PW'(1);
            if (accept) begin
                wptr_q <= wbase + PW'(1);
                if (is_commit) begin
                    cptr_q <= wbase + PW'(1);
                    open_q <= 1'b0;
                end else begin
                    open_q <= 1'b1;
                end
            end
            if (drop) ovf_q <= 1'b1;
            if (misuse || underflow) state_q <= QS_STUCK;
        end
    end

    // Drive storage and status outputs
    always_comb begin
        mem_we    = accept;
        mem_waddr = wbase[AW-1:0];
        mem_wlast = is_commit;
        mem_raddr = rptr_q[AW-1:0];
        rd_valid  = head_ok;
        empty     = comm_empty;
        arb_req   = arb_q;
        stuck     = (state_q == QS_STUCK);
        overflow  = ovf_q;
    end

endmodule

// File: rtl/txq_commit_fifo.sv
// Module: txq_commit_fifo (top)
// Staged-commit transmit queue: register bus writes carry framing in the
// address, a commit releases a whole packet to the read side, faults latch
// a stuck state until clr_fifo. ISO_MAP selects the address map.
// Assumes DEPTH is a power of two and ADDR_W >= 8.
module txq_commit_fifo #(
    parameter int ISO_MAP = 0,
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 16,
    parameter int ADDR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_fifo,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    output logic              empty,
    output logic              arb_req,
    output logic              stuck,
    output logic              overflow
);

    localparam int AW = $clog2(DEPTH);

    txq_pkg::wkind_e kind;
    logic            mem_we, mem_wlast;
    logic [AW-1:0]   mem_waddr, mem_raddr;

    txq_addr_decode #(.ISO_MAP(ISO_MAP), .ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .kind    (kind)
    );

    txq_frame_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_fifo),
        .kind      (kind),
        .rd_en     (rd_en),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wlast (mem_wlast),
        .mem_raddr (mem_raddr),
        .rd_valid  (rd_valid),
        .empty     (empty),
        .arb_req   (arb_req),
        .stuck     (stuck),
        .overflow  (overflow)
    );

    txq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .wlast (mem_wlast),
        .raddr (mem_raddr),
        .rdata (rd_data),
        .rlast (rd_last)
    );

endmodule

// File: rtl/txq_commit_fifo_chk.sv
// Module: txq_commit_fifo_chk
// Port-level temporal checks for txq_commit_fifo, bound to every instance.
module txq_commit_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic clr_fifo,
    input logic rd_en,
    input logic rd_valid,
    input logic empty,
    input logic arb_req,
    input logic stuck,
    input logic overflow
);

    assert_stuck_blocks_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !stuck);

    assert_stuck_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck && !clr_fifo) |=> stuck);

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fifo |=> (empty && !stuck && !overflow && !rd_valid));

    assert_arb_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req |-> !empty);

    assert_arb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arb_req |=> !arb_req);

    assert_underflow_stuck_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_valid && !stuck && !clr_fifo) |=> stuck);

    assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr_fifo) |=> overflow);

    assert_valid_not_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !empty);

endmodule

bind txq_commit_fifo txq_commit_fifo_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_fifo (clr_fifo),
    .rd_en    (rd_en),
    .rd_valid (rd_valid),
    .empty    (empty),
    .arb_req  (arb_req),
    .stuck    (stuck),
    .overflow (overflow)
);

// File: tb/sim_txq_commit_fifo.sv
// Bench: one asynchronous-map instance (u0) and one isochronous-map
// instance (u1), DEPTH=4, sharing the write bus and clear.
module sim_txq_commit_fifo;

    localparam int DW = 32;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          clr_fifo = 1'b0;
    logic          rd_en_a = 1'b0, rd_en_i = 1'b0;

    logic [DW-1:0] rd_data_a, rd_data_i;
    logic          rd_valid_a, rd_last_a, empty_a, arb_a, stuck_a, ovf_a;
    logic          rd_valid_i, rd_last_i, empty_i, arb_i, stuck_i, ovf_i;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    txq_commit_fifo #(.ISO_MAP(0), .DATA_W(DW), .DEPTH(DP), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_fifo(clr_fifo), .rd_en(rd_en_a), .rd_data(rd_data_a), .rd_valid(rd_valid_a),
        .rd_last(rd_last_a), .empty(empty_a), .arb_req(arb_a), .stuck(stuck_a),
        .overflow(ovf_a)
    );

    txq_commit_fifo #(.ISO_MAP(1), .DATA_W(DW), .DEPTH(DP), .ADDR_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .clr_fifo(clr_fifo), .rd_en(rd_en_i), .rd_data(rd_data_i), .rd_valid(rd_valid_i),
        .rd_last(rd_last_i), .empty(empty_i), .arb_req(arb_i), .stuck(stuck_i),
        .overflow(ovf_i)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic edge_wait();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        edge_wait();
        wr_en = 1'b0;
    endtask

    task automatic clear_all();
        clr_fifo = 1'b1;
        edge_wait();
        clr_fifo = 1'b0;
    endtask

    task automatic pop_a(input string req, input logic [DW-1:0] d, input logic l);
        chk(req, "async valid", DW'(rd_valid_a), 1);
        chk(req, "async data", rd_data_a, d);
        chk(req, "async last", DW'(rd_last_a), DW'(l));
        rd_en_a = 1'b1;
        edge_wait();
        rd_en_a = 1'b0;
    endtask

    task automatic pop_i(input string req, input logic [DW-1:0] d, input logic l);
        chk(req, "iso valid", DW'(rd_valid_i), 1);
        chk(req, "iso data", rd_data_i, d);
        chk(req, "iso last", DW'(rd_last_i), DW'(l));
        rd_en_i = 1'b1;
        edge_wait();
        rd_en_i = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int tag, input int len, input int i);
        return DW'(tag) * 32'h0001_0000 + DW'(len) * 32'h100 + DW'(i);
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11: reset state
        chk("R11", "empty_a", DW'(empty_a), 1);
        chk("R11", "valid_a", DW'(rd_valid_a), 0);
        chk("R11", "arb_a", DW'(arb_a), 0);
        chk("R11", "stuck_a", DW'(stuck_a), 0);
        chk("R11", "ovf_a", DW'(ovf_a), 0);
        chk("R11", "stuck_i", DW'(stuck_i), 0);

        // R1 R2 R3 R8: async sweep over packet lengths
        for (int len = 2; len <= DP; len++) begin
            wr(8'h80, pat(1, len, 0));
            chk("R2", "hidden after open", DW'(rd_valid_a), 0);
            for (int i = 1; i < len - 1; i++) begin
                wr(8'h84, pat(1, len, i));
                chk("R2", "hidden after append", DW'(rd_valid_a), 0);
                chk("R2", "empty while open", DW'(empty_a), 1);
            end
            wr(8'h8C, pat(1, len, len - 1));
            chk("R8", "arb pulse", DW'(arb_a), 1);
            chk("R8", "empty drops", DW'(empty_a), 0);
            chk("R2", "visible after close", DW'(rd_valid_a), 1);
            chk("R1", "iso ignores async map", DW'(rd_valid_i | stuck_i), 0);
            chk("R10", "exact fill no overflow", DW'(ovf_a), 0);
            edge_wait();
            chk("R8", "arb one cycle", DW'(arb_a), 0);
            for (int i = 0; i < len; i++) pop_a("R3", pat(1, len, i), i == len - 1);
            chk("R3", "drained", DW'(empty_a), 1);
        end

        // R1 R2 R3 R8: iso sweep, length 1 uses open-and-close
        for (int len = 1; len <= DP; len++) begin
            if (len == 1) begin
                wr(8'h98, pat(2, 1, 0));
            end else begin
                wr(8'h90, pat(2, len, 0));
                chk("R2", "iso hidden", DW'(rd_valid_i), 0);
                for (int i = 1; i < len - 1; i++) wr(8'h94, pat(2, len, i));
                wr(8'h9C, pat(2, len, len - 1));
            end
            chk("R8", "iso arb pulse", DW'(arb_i), 1);
            chk("R1", "async ignores iso map", DW'(rd_valid_a | stuck_a), 0);
            edge_wait();
            for (int i = 0; i < len; i++) pop_i("R3", pat(2, len, i), i == len - 1);
        end

        // R8: second commit into non-empty queue raises no request
        wr(8'h80, pat(3, 0, 0)); wr(8'h8C, pat(3, 0, 1));
        edge_wait();
        wr(8'h80, pat(3, 1, 0)); wr(8'h8C, pat(3, 1, 1));
        chk("R8", "no arb when non-empty", DW'(arb_a), 0);
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 2; i++) pop_a("R3", pat(3, p, i), i == 1);

        // R1: unmapped async offset 88h ignored; 98h goes to iso only
        wr(8'h80, pat(4, 0, 0));
        wr(8'h88, pat(4, 0, 9));
        wr(8'h98, pat(4, 1, 0));
        wr(8'h8C, pat(4, 0, 1));
        pop_a("R1", pat(4, 0, 0), 1'b0);
        pop_a("R1", pat(4, 0, 1), 1'b1);
        chk("R1", "async only two", DW'(rd_valid_a), 0);
        pop_i("R1", pat(4, 1, 0), 1'b1);

        // R9: reopening discards uncommitted quadlets (both maps)
        wr(8'h80, pat(5, 0, 0)); wr(8'h84, pat(5, 0, 1));
        wr(8'h80, pat(5, 0, 2)); wr(8'h8C, pat(5, 0, 3));
        pop_a("R9", pat(5, 0, 2), 1'b0);
        pop_a("R9", pat(5, 0, 3), 1'b1);
        chk("R9", "async discarded", DW'(rd_valid_a), 0);
        wr(8'h90, pat(5, 1, 0)); wr(8'h94, pat(5, 1, 1)); wr(8'h98, pat(5, 1, 2));
        pop_i("R9", pat(5, 1, 2), 1'b1);
        chk("R9", "iso discarded", DW'(rd_valid_i), 0);

        // R10: write to full queue dropped, overflow sticky; R7 clears it
        wr(8'h80, pat(6, 0, 0));
        for (int i = 1; i < DP; i++) wr(8'h84, pat(6, 0, i));
        chk("R10", "full not flagged", DW'(ovf_a), 0);
        wr(8'h84, pat(6, 0, 7));
        chk("R10", "overflow set", DW'(ovf_a), 1);
        wr(8'h8C, pat(6, 0, 8));
        chk("R10", "dropped close no commit", DW'(rd_valid_a), 0);
        chk("R10", "overflow sticky", DW'(ovf_a), 1);
        chk("R10", "iso no overflow", DW'(ovf_i), 0);
        clear_all();
        chk("R7", "overflow cleared", DW'(ovf_a), 0);
        chk("R7", "empty after clear", DW'(empty_a), 1);

        // R4 R6: append without open; stuck blocks writes
        wr(8'h84, pat(7, 0, 0));
        chk("R4", "append w/o open stuck", DW'(stuck_a), 1);
        chk("R4", "iso unaffected", DW'(stuck_i), 0);
        wr(8'h80, pat(7, 0, 1)); wr(8'h8C, pat(7, 0, 2));
        chk("R6", "writes ignored", DW'(empty_a), 1);
        chk("R6", "still stuck", DW'(stuck_a), 1);
        clear_all();
        chk("R7", "stuck released", DW'(stuck_a), 0);

        // R4 R6: close with no open packet while data is committed
        wr(8'h80, pat(8, 0, 0)); wr(8'h8C, pat(8, 0, 1));
        wr(8'h8C, pat(8, 0, 2));
        chk("R4", "close w/o open stuck", DW'(stuck_a), 1);
        chk("R6", "read blocked", DW'(rd_valid_a), 0);
        rd_en_a = 1'b1; edge_wait(); rd_en_a = 1'b0;
        chk("R6", "pop ignored", DW'(empty_a), 0);
        clear_all();
        chk("R7", "clear empties", DW'(empty_a), 1);
        wr(8'h80, pat(8, 1, 0)); wr(8'h8C, pat(8, 1, 1));
        pop_a("R7", pat(8, 1, 0), 1'b0);
        pop_a("R7", pat(8, 1, 1), 1'b1);

        // R4: iso close without open; async keeps working
        wr(8'h9C, pat(9, 0, 0));
        chk("R4", "iso stuck", DW'(stuck_i), 1);
        wr(8'h80, pat(9, 1, 0)); wr(8'h8C, pat(9, 1, 1));
        chk("R6", "iso held", DW'(rd_valid_i), 0);
        pop_a("R4", pat(9, 1, 0), 1'b0);
        pop_a("R4", pat(9, 1, 1), 1'b1);
        clear_all();

        // R5: pop on empty queue
        rd_en_a = 1'b1; edge_wait(); rd_en_a = 1'b0;
        chk("R5", "underflow stuck", DW'(stuck_a), 1);
        chk("R5", "iso unaffected", DW'(stuck_i), 0);
        clear_all();

        // R8 R3: close and pop in the same cycle
        wr(8'h80, pat(10, 0, 0)); wr(8'h8C, pat(10, 0, 1));
        wr(8'h80, pat(10, 1, 0));
        chk("R3", "head before overlap", rd_data_a, pat(10, 0, 0));
        wr_en = 1'b1; wr_addr = 8'h8C; wr_data = pat(10, 1, 1); rd_en_a = 1'b1;
        edge_wait();
        wr_en = 1'b0; rd_en_a = 1'b0;
        chk("R8", "no arb on overlap", DW'(arb_a), 0);
        pop_a("R3", pat(10, 0, 1), 1'b1);
        pop_a("R3", pat(10, 1, 0), 1'b0);
        pop_a("R3", pat(10, 1, 1), 1'b1);
        chk("R3", "overlap drained", DW'(empty_a), 1);

        // R4 R5: framing fault and pop in the same cycle: pop still lands
        wr(8'h80, pat(11, 0, 0)); wr(8'h8C, pat(11, 0, 1));
        wr_en = 1'b1; wr_addr = 8'h84; wr_data = '0; rd_en_a = 1'b1;
        edge_wait();
        wr_en = 1'b0; rd_en_a = 1'b0;
        chk("R4", "fault with pop stuck", DW'(stuck_a), 1);
        clr_fifo = 1'b1; edge_wait(); clr_fifo = 1'b0;
        chk("R7", "cleared", DW'(stuck_a), 0);

        // R7: clear beats same-cycle open write
        clr_fifo = 1'b1; wr_en = 1'b1; wr_addr = 8'h80; wr_data = pat(12, 0, 0);
        edge_wait();
        clr_fifo = 1'b0; wr_en = 1'b0;
        wr(8'h8C, pat(12, 0, 1));
        chk("R7", "open lost to clear", DW'(stuck_a), 1);
        clear_all();

        done = 1;
        summary();
        $finish;
    end

endmodule